// File: doc/BRIEF.md
# Shift, Rotate and Nibble-Rotate Unit

This block is the single-bit shift and rotate datapath of an 8-bit processor core, together with the two hex-digit rotates. The hex-digit rotates spread 12 bits across the accumulator and one memory byte. Each cycle the core presents an operation code, the operand byte, the current flag byte and, for the digit rotates, the memory byte. One clock later the unit returns four values: the result byte, the byte to write back to memory, the new flag byte, and a mask that names the flag bits the operation defines.

Each of the four rotates comes in two forms that produce the same data. The general form rewrites the whole flag set from the result. The short accumulator form touches only the carry and clears the half-carry and subtract bits, and it leaves sign, zero and parity unchanged. Opcode decode and memory sequencing belong to the surrounding core.

Top module: `shift_rot_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all four outputs become 0 at that edge.
- R2: Every output is registered. The values for the inputs sampled at rising edge k appear after edge k and hold until edge k+1.
- R3: Through-carry rotates. Code 0 (left) gives `{a[6:0], cin}` with carry-out `a[7]`. Code 1 (right) gives `{cin, a[7:1]}` with carry-out `a[0]`. `cin` is `flags_i[0]`. Example: 0x95 with cin 0 rotated left gives 0x2A with carry 1.
- R4: Circular rotates. Code 2 (left) gives `{a[6:0], a[7]}` with carry-out `a[7]`. Code 3 (right) gives `{a[0], a[7:1]}` with carry-out `a[0]`. Example: 0x95 rotated left gives 0x2B with carry 1.
- R5: Code 4 shifts left, fills bit 0 with 0 and sends `a[7]` to carry. Code 6 shifts right logically, fills bit 7 with 0 and sends `a[0]` to carry.
- R6: Code 5 shifts right arithmetically. Bit 7 is kept and `a[0]` goes to carry. Example: 0xFC gives 0xFE.
- R7: Code 7 is the left digit rotate. The result is `{a[7:4], m[7:4]}` and the memory output is `{m[3:0], a[3:0]}`. Example: a=0x25, m=0xEB gives 0x2E and 0xB5.
- R8: Code 8 is the right digit rotate. The result is `{a[7:4], m[3:0]}` and the memory output is `{a[3:0], m[7:4]}`. Example: 0x25, 0xEB gives 0x2B and 0x5E. Applying it twice equals one left digit rotate.
- R9: Flag positions are S=7, Z=6, H=4, P/V=2, N=1, C=0. For codes 0 to 6, S is `res[7]`, Z is 1 when `res` is 0, P/V is 1 on even parity of `res`, H and N are 0, and C is the bit shifted out.
- R10: Codes 9, 10, 11 and 12 produce the same data as codes 0, 1, 2 and 3. They set C to the shifted-out bit, clear H and N, and copy S, Z and P/V from `flags_i`.
- R11: For codes 7 and 8, S, Z and P/V follow R9 and H and N are cleared, but C is copied from `flags_i[0]`.
- R12: `mask_o` is 0xD7 for codes 0 to 6, 0x13 for codes 9 to 12, and 0xD6 for codes 7 and 8. Flag bits 5 and 3 always copy `flags_i`.
- R13: Codes 13 to 15 are no-ops. The result equals the operand, `flags_o` equals `flags_i`, and `mask_o` is 0. For every code other than 7 and 8, `mem_o` equals `mem_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Operand (accumulator for digit rotates) |
| mem_i | input | 8 | Memory byte for digit rotates |
| flags_i | input | 8 | Current flag byte, bit 0 is carry-in |
| res_o | output | 8 | Result byte |
| mem_o | output | 8 | Memory byte to write back |
| flags_o | output | 8 | New flag byte |
| mask_o | output | 8 | Flag bits defined by the operation |

## Verification
All four results (result, memory byte, flags and mask) are due exactly one clock after the inputs are sampled, because each passes through one output register. The bench changes inputs on the falling edge and, at the next falling edge, compares every output with the model value it computed from the inputs that edge captured. One directed check samples just before the capturing edge to confirm the previous value still holds there.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

    parameter int BYTE_W = 8;
    localparam int NIB_W = BYTE_W / 2;

    // flag bit positions (decoded by condition logic elsewhere)
    localparam int FL_S  = 7;
    localparam int FL_Z  = 6;
    localparam int FL_H  = 4;
    localparam int FL_PV = 2;
    localparam int FL_N  = 1;
    localparam int FL_C  = 0;

    localparam logic [7:0] MASK_GEN = 8'hD7;
    localparam logic [7:0] MASK_ACC = 8'h13;
    localparam logic [7:0] MASK_NIB = 8'hD6;
    localparam logic [7:0] KEEP_BITS = 8'h28;

    typedef enum logic [3:0] {
        OP_RLT   = 4'd0,
        OP_RRT   = 4'd1,
        OP_RLCIR = 4'd2,
        OP_RRCIR = 4'd3,
        OP_SHL   = 4'd4,
        OP_SAR   = 4'd5,
        OP_SHR   = 4'd6,
        OP_NIBL  = 4'd7,
        OP_NIBR  = 4'd8,
        OP_ARLT  = 4'd9,
        OP_ARRT  = 4'd10,
        OP_ARLC  = 4'd11,
        OP_ARRC  = 4'd12,
        OP_NOP13 = 4'd13,
        OP_NOP14 = 4'd14,
        OP_NOP15 = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        FK_GEN,
        FK_ACC,
        FK_NIB,
        FK_NONE
    } flag_kind_e;

    typedef enum logic [2:0] {
        SH_RL_THRU,
        SH_RR_THRU,
        SH_RL_CIRC,
        SH_RR_CIRC,
        SH_LEFT_ZERO,
        SH_RIGHT_SIGN,
        SH_RIGHT_ZERO,
        SH_PASS
    } shift_kind_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              cout;
    } shift_res_t;

    typedef struct packed {
        logic [BYTE_W-1:0] acc;
        logic [BYTE_W-1:0] mem;
    } nib_res_t;

    typedef struct packed {
        shift_kind_e shk;
        flag_kind_e  fk;
        logic        nib;
        logic        nib_left;
    } op_dec_t;

    function automatic op_dec_t decode_op(input op_e op);
        op_dec_t d;
        d = '{shk: SH_PASS, fk: FK_NONE, nib: 1'b0, nib_left: 1'b0};
        unique case (op)
            OP_RLT:   begin d.shk = SH_RL_THRU;    d.fk = FK_GEN; end
            OP_RRT:   begin d.shk = SH_RR_THRU;    d.fk = FK_GEN; end
            OP_RLCIR: begin d.shk = SH_RL_CIRC;    d.fk = FK_GEN; end
            OP_RRCIR: begin d.shk = SH_RR_CIRC;    d.fk = FK_GEN; end
            OP_SHL:   begin d.shk = SH_LEFT_ZERO;  d.fk = FK_GEN; end
            OP_SAR:   begin d.shk = SH_RIGHT_SIGN; d.fk = FK_GEN; end
            OP_SHR:   begin d.shk = SH_RIGHT_ZERO; d.fk = FK_GEN; end
            OP_NIBL:  begin d.nib = 1'b1; d.nib_left = 1'b1; d.fk = FK_NIB; end
            OP_NIBR:  begin d.nib = 1'b1; d.fk = FK_NIB; end
            OP_ARLT:  begin d.shk = SH_RL_THRU;    d.fk = FK_ACC; end
            OP_ARRT:  begin d.shk = SH_RR_THRU;    d.fk = FK_ACC; end
            OP_ARLC:  begin d.shk = SH_RL_CIRC;    d.fk = FK_ACC; end
            OP_ARRC:  begin d.shk = SH_RR_CIRC;    d.fk = FK_ACC; end
            default:  begin d.shk = SH_PASS;       d.fk = FK_NONE; end
        endcase
        return d;
    endfunction

    function automatic logic even_parity(input logic [BYTE_W-1:0] v);
        return ~(^v);
    endfunction

endpackage

// File: rtl/su_bit_shifter.sv
module su_bit_shifter
    import shift_unit_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  shift_kind_e    kind,
    input  logic [W-1:0]   a,
    input  logic           cin,
    output shift_res_t     res
);
    localparam int MSB = W - 1;

    logic [W-1:0] from_right;  // bit i takes a[i-1]
    logic [W-1:0] from_left;   // bit i takes a[i+1]

    genvar gi;
    generate
        for (gi = 1; gi < W; gi++) begin : g_left_tap
            assign from_right[gi] = a[gi-1];
        end
        for (gi = 0; gi < W - 1; gi++) begin : g_right_tap
            assign from_left[gi] = a[gi+1];
        end
    endgenerate

    logic fill_lsb;
    logic fill_msb;

    always_comb begin
        fill_lsb = 1'b0;
        fill_msb = 1'b0;
        unique case (kind)
            SH_RL_THRU:    fill_lsb = cin;
            SH_RL_CIRC:    fill_lsb = a[MSB];
            SH_RR_THRU:    fill_msb = cin;
            SH_RR_CIRC:    fill_msb = a[0];
            SH_RIGHT_SIGN: fill_msb = a[MSB];
            default: begin
                fill_lsb = 1'b0;
                fill_msb = 1'b0;
            end
        endcase
    end

    logic [W-1:0] left_word;
    logic [W-1:0] right_word;

    always_comb begin
        left_word           = from_right;
        left_word[0]        = fill_lsb;
        right_word          = from_left;
        right_word[MSB]     = fill_msb;
    end

    always_comb begin
        unique case (kind)
            SH_RL_THRU, SH_RL_CIRC, SH_LEFT_ZERO: begin
                res.data = left_word;
                res.cout = a[MSB];
            end
            SH_RR_THRU, SH_RR_CIRC, SH_RIGHT_SIGN, SH_RIGHT_ZERO: begin
                res.data = right_word;
                res.cout = a[0];
            end
            default: begin
                res.data = a;
                res.cout = cin;
            end
        endcase
    end
endmodule

// File: rtl/su_nibble_rot.sv
module su_nibble_rot
    import shift_unit_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic         left,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] mem,
    output nib_res_t     res
);
    localparam int H = W / 2;

    logic [H-1:0] acc_hi, acc_lo, mem_hi, mem_lo;

    always_comb begin
        acc_hi = acc[W-1:H];
        acc_lo = acc[H-1:0];
        mem_hi = mem[W-1:H];
        mem_lo = mem[H-1:0];
        if (left) begin
            res.acc = {acc_hi, mem_hi};
            res.mem = {mem_lo, acc_lo};
        end else begin
            res.acc = {acc_hi, mem_lo};
            res.mem = {acc_lo, mem_hi};
        end
    end
endmodule

// File: rtl/su_flag_gen.sv
module su_flag_gen
    import shift_unit_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  flag_kind_e   kind,
    input  logic [W-1:0] result,
    input  logic         cout,
    input  logic [7:0]   flags_in,
    output logic [7:0]   flags_out,
    output logic [7:0]   mask
);
    logic s_bit, z_bit, p_bit;

    always_comb begin
        s_bit = result[W-1];
        z_bit = (result == '0);
        p_bit = even_parity(result);
    end

    always_comb begin
        flags_out = flags_in;
        mask      = '0;
        unique case (kind)
            FK_GEN: begin
                flags_out[FL_S]  = s_bit;
                flags_out[FL_Z]  = z_bit;
                flags_out[FL_PV] = p_bit;
                flags_out[FL_H]  = 1'b0;
                flags_out[FL_N]  = 1'b0;
                flags_out[FL_C]  = cout;
                mask             = MASK_GEN;
            end
            FK_NIB: begin
                flags_out[FL_S]  = s_bit;
                flags_out[FL_Z]  = z_bit;
                flags_out[FL_PV] = p_bit;
                flags_out[FL_H]  = 1'b0;
                flags_out[FL_N]  = 1'b0;
                mask             = MASK_NIB;
            end
            FK_ACC: begin
                flags_out[FL_H]  = 1'b0;
                flags_out[FL_N]  = 1'b0;
                flags_out[FL_C]  = cout;
                mask             = MASK_ACC;
            end
            default: begin
                flags_out = flags_in;
                mask      = '0;
            end
        endcase
    end
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
    import shift_unit_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [DATA_W-1:0] mem_i,
    input  logic [7:0]        flags_i,
    output logic [DATA_W-1:0] res_o,
    output logic [DATA_W-1:0] mem_o,
    output logic [7:0]        flags_o,
    output logic [7:0]        mask_o
);
    op_dec_t    dec;
    shift_res_t sh;
    nib_res_t   nb;

    logic [DATA_W-1:0] res_n, mem_n;
    logic              cout_n;
    logic [7:0]        flags_n, mask_n;

    always_comb dec = decode_op(op_e'(op_i));

    su_bit_shifter #(.W(DATA_W)) u_shift (
        .kind (dec.shk),
        .a    (opnd_i),
        .cin  (flags_i[FL_C]),
        .res  (sh)
    );

    su_nibble_rot #(.W(DATA_W)) u_nib (
        .left (dec.nib_left),
        .acc  (opnd_i),
        .mem  (mem_i),
        .res  (nb)
    );

    always_comb begin
        if (dec.nib) begin
            res_n  = nb.acc;
            mem_n  = nb.mem;
            cout_n = flags_i[FL_C];
        end else begin
            res_n  = sh.data;
            mem_n  = mem_i;
            cout_n = sh.cout;
        end
    end

    su_flag_gen #(.W(DATA_W)) u_flags (
        .kind      (dec.fk),
        .result    (res_n),
        .cout      (cout_n),
        .flags_in  (flags_i),
        .flags_out (flags_n),
        .mask      (mask_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o   <= '0;
            mem_o   <= '0;
            flags_o <= '0;
            mask_o  <= '0;
        end else begin
            res_o   <= res_n;
            mem_o   <= mem_n;
            flags_o <= flags_n;
            mask_o  <= mask_n;
        end
    end
endmodule

// File: rtl/su_checker.sv
module su_checker
    import shift_unit_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] opnd_i,
    input logic [DATA_W-1:0] mem_i,
    input logic [7:0]        flags_i,
    input logic [DATA_W-1:0] res_o,
    input logic [DATA_W-1:0] mem_o,
    input logic [7:0]        flags_o,
    input logic [7:0]        mask_o
);
    logic primed;
    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // R10: short rotates keep S, Z and P/V
    p_acc_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_i) >= 4'd9 && $past(op_i) <= 4'd12) |->
        (flags_o[FL_S] == $past(flags_i[FL_S]) && flags_o[FL_Z] == $past(flags_i[FL_Z])
         && flags_o[FL_PV] == $past(flags_i[FL_PV])));

    // R11: digit rotates keep carry
    p_nib_carry_r11: assert property (@(posedge clk) disable iff (rst)
        (primed && ($past(op_i) == 4'd7 || $past(op_i) == 4'd8)) |->
        flags_o[FL_C] == $past(flags_i[FL_C]));

    // R9: parity flag tracks result for general ops
    p_parity_r9: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_i) <= 4'd8) |-> flags_o[FL_PV] == ~(^res_o));

    // R9: half-carry and subtract cleared by every defined op
    p_hn_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_i) <= 4'd12) |-> (!flags_o[FL_H] && !flags_o[FL_N]));

    // R13: memory byte passes through for non-digit ops
    p_mem_pass_r13: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_i) != 4'd7 && $past(op_i) != 4'd8) |-> mem_o == $past(mem_i));

    // R13: no-op codes leave flags and data untouched
    p_nop_r13: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_i) >= 4'd13) |->
        (res_o == $past(opnd_i) && flags_o == $past(flags_i) && mask_o == 8'h00));

    // R12: reserved flag bits copy input
    p_keep_bits_r12: assert property (@(posedge clk) disable iff (rst)
        primed |-> (flags_o[5] == $past(flags_i[5]) && flags_o[3] == $past(flags_i[3])));

    // R6: arithmetic right shift keeps sign bit
    p_sar_sign_r6: assert property (@(posedge clk) disable iff (rst)
        (primed && $past(op_i) == 4'd5) |-> res_o[DATA_W-1] == $past(opnd_i[DATA_W-1]));
endmodule

bind shift_rot_unit su_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .opnd_i(opnd_i), .mem_i(mem_i),
    .flags_i(flags_i), .res_o(res_o), .mem_o(mem_o), .flags_o(flags_o), .mask_o(mask_o)
);

// File: tb/shift_rot_unit_tb.sv
`timescale 1ns/1ps
module shift_rot_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_i = '0;
    logic [7:0] opnd_i = '0, mem_i = '0, flags_i = '0;
    logic [7:0] res_o, mem_o, flags_o, mask_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit pending = 0;
    int e_res, e_mem, e_flg, e_msk, e_op;

    always #2 clk = ~clk;

    shift_rot_unit u_dut (
        .clk(clk), .rst(rst), .op_i(op_i), .opnd_i(opnd_i), .mem_i(mem_i),
        .flags_i(flags_i), .res_o(res_o), .mem_o(mem_o), .flags_o(flags_o), .mask_o(mask_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    function automatic string data_req(input int op);
        case (op)
            0, 1, 9, 10:  return "R3";
            2, 3, 11, 12: return "R4";
            4, 6:         return "R5";
            5:            return "R6";
            7:            return "R7";
            8:            return "R8";
            default:      return "R13";
        endcase
    endfunction

    function automatic string flag_req(input int op);
        if (op <= 6) return "R9";
        if (op <= 8) return "R11";
        if (op <= 12) return "R10";
        return "R13";
    endfunction

    // behavioural reference model
    task automatic model(input int op, input int a, input int m, input int f,
                         output int r, output int mo, output int fo, output int mk);
        int c, co, ones, base;
        c = f & 1;
        base = (op >= 9 && op <= 12) ? op - 9 : op;
        mo = m; co = c; r = a;
        case (base)
            0: begin r = ((a * 2) + c) % 256;            co = a / 128; end
            1: begin r = (a / 2) + c * 128;              co = a % 2;   end
            2: begin r = ((a * 2) + a / 128) % 256;      co = a / 128; end
            3: begin r = (a / 2) + (a % 2) * 128;        co = a % 2;   end
            4: begin r = (a * 2) % 256;                  co = a / 128; end
            5: begin r = (a / 2) + (a / 128) * 128;      co = a % 2;   end
            6: begin r = a / 2;                          co = a % 2;   end
            7: begin r = (a / 16) * 16 + m / 16; mo = (m % 16) * 16 + a % 16; end
            8: begin r = (a / 16) * 16 + m % 16; mo = (a % 16) * 16 + m / 16; end
            default: r = a;
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
        if (op <= 6) begin
            fo = (f & 'h28) | (r >= 128 ? 128 : 0) | (r == 0 ? 64 : 0)
                 | (ones % 2 == 0 ? 4 : 0) | co;
            mk = 'hD7;
        end else if (op <= 8) begin
            fo = (f & 'h29) | (r >= 128 ? 128 : 0) | (r == 0 ? 64 : 0)
                 | (ones % 2 == 0 ? 4 : 0);
            mk = 'hD6;
        end else if (op <= 12) begin
            fo = (f & 'hEC) | co;
            mk = 'h13;
        end else begin
            fo = f; mk = 0;
        end
    endtask

    // one clock per call: check previous vector, apply the new one (R2 latency)
    task automatic step(input int op, input int a, input int m, input int f);
        @(negedge clk);
        if (pending) begin
            chk(data_req(e_op), res_o, e_res);
            chk((e_op == 7 || e_op == 8) ? data_req(e_op) : "R13", mem_o, e_mem);
            chk(flag_req(e_op), flags_o, e_flg);
            chk("R12", mask_o, e_msk);
        end
        op_i = op[3:0]; opnd_i = a[7:0]; mem_i = m[7:0]; flags_i = f[7:0];
        model(op, a, m, f, e_res, e_mem, e_flg, e_msk);
        e_op = op;
        pending = 1;
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int r, mo, fo, mk, r2, mo2;
        op_i = 4'd4; opnd_i = 8'hFF; mem_i = 8'h77; flags_i = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", res_o, 0); chk("R1", mem_o, 0);
        chk("R1", flags_o, 0); chk("R1", mask_o, 0);
        rst = 0;

        // document examples
        step(0, 'h95, 0, 'h00);
        // expected 0x2A, C=1, flags 0x01
        step(2, 'h95, 0, 'h00);
        step(5, 'hFC, 0, 'h00);
        step(7, 'h25, 'hEB, 'h00);
        step(8, 'h25, 'hEB, 'h01);
        step(9, 'h95, 0, 'hC4);
        step(11, 'h95, 0, 'h00);
        step(4, 'h80, 'h11, 'h00);   // zero result, carry out
        step(6, 'h01, 0, 'hFF);
        step(1, 'h01, 0, 'h01);
        step(3, 'h01, 0, 'h00);
        step(10, 'h02, 0, 'h29);
        step(12, 'h00, 0, 'hFF);
        step(14, 'h5A, 'h3C, 'hAB);

        // explicit spot values
        @(negedge clk);
        chk("R13", res_o, 'h5A); chk("R13", flags_o, 'hAB); chk("R13", mask_o, 0);
        pending = 0;

        // R2: value held until capturing edge
        op_i = 4'd0; opnd_i = 8'h95; flags_i = 8'h00;
        #1 chk("R2", res_o, 'h5A);
        @(negedge clk);
        chk("R3", res_o, 'h2A); chk("R9", flags_o, 'h01);

        // R8: double right digit rotate equals one left
        model(8, 'h25, 'hEB, 0, r, mo, fo, mk);
        model(8, r, mo, 0, r2, mo2, fo, mk);
        model(7, 'h25, 'hEB, 0, r, mo, fo, mk);
        chk("R8", r2, r); chk("R8", mo2, mo);
        op_i = 4'd8; opnd_i = 8'h25; mem_i = 8'hEB;
        @(negedge clk);
        opnd_i = res_o; mem_i = mem_o;
        @(negedge clk);
        chk("R8", res_o, 'h2E); chk("R8", mem_o, 'hB5);

        // randomized sweep over all codes
        for (int k = 0; k < 600; k++)
            step($urandom % 16, $urandom % 256, $urandom % 256, $urandom % 256);
        step(13, 0, 0, 0);
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule